// File: doc/BRIEF.md
# Line Brownout Qualifier

This block decides whether the rectified input line of a power-factor stage has sagged too far to keep switching. Each line measurement arrives as a fixed-point value in units of 0.1 % of the nominal line reference, together with a one-cycle valid strobe. A separate one-cycle pulse marks every elapsed millisecond. The block turns these into a debounced brownout flag and a gate-disable request, which downstream gate-drive logic uses to hold the power switch off.

Going into brownout and coming out of it are qualified separately. Each direction has its own threshold and its own millisecond timer. The entry delay grows with how far the line has fallen during the current run, so brief deep notches must last longer before they trip the flag. Any measurement that contradicts the condition being timed restarts that timer from zero. The block leaves reset in brownout, so the gate stays off until the line has proven itself good. A full-scale code is taken to mean a broken sense path and is handled as a low line.

Top module: `line_brownout_qual`

## Requirements
- R1: While reset is active and in the first cycle after reset is released, `brownout` and `gate_off` are both 1.
- R2: A sampled value counts as low when it is at most ENTER_LVL (default 490, i.e. 49.0 %). With the default parameters, 490 counts as low and 491 does not, so a steady 491 never produces brownout.
- R3: With the line normal, a low sample of depth zero (value 490) that is held raises `brownout` at the clock edge of the ENTER_MS-th (56th) millisecond tick counted. A tick in the same cycle as the arming sample counts.
- R4: The entry delay in ticks is ENTER_MS + min(depth >> EXT_SHIFT, EXT_MAX_MS), which is 56 + min(depth/2, 200) by default. Here depth = ENTER_LVL − v, and v is the lowest value sampled in the current entry run.
- R5: A later, shallower low sample in the same run does not shorten the entry delay that an earlier, deeper sample has set.
- R6: While the line is normal, a sample that is not low clears the entry timer and the recorded depth. A fresh run then needs the full delay again.
- R7: While in brownout, a sample counts as good only when it is strictly above EXIT_LVL (default 564, i.e. 56.4 %). With good samples held, `brownout` clears at the clock edge of the EXIT_MS-th (56th) tick. A steady 564 never clears the flag.
- R8: While in brownout, a sample that is not good clears the exit timer. Recovery then needs EXIT_MS fresh ticks.
- R9: The all-ones code (2047 at the default 11-bit width) counts as low with the largest depth, which gives a 256-tick entry delay. It never counts as good.
- R10: Timers advance only on `ms_tick`. Cycles without a tick, and repeated samples of the same kind, do not change the flag or shorten the remaining delay.
- R11: `gate_off` is always equal to `brownout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | One-cycle strobe marking a new line measurement |
| line_pct | input | VAL_W | Line measurement in 0.1 % units of reference; all ones marks a sense fault |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| brownout | output | 1 | Line is qualified as being in brownout |
| gate_off | output | 1 | Request to hold the gate drive off |

## Verification
On every cycle, the bound checker verifies these things:
- The flag only changes on a cycle that carries a millisecond tick.
- At least ENTER_MS or EXIT_MS ticks have elapsed since the previous change.
- The most recent sample was low before any entry and good before any exit, so a fault code can never release the gate.

The exact delays are shown only by the bench's scenarios: the depth-dependent entry time across a sweep of line levels, the restarts after an interrupting sample, the threshold codes on either side of each limit, and the fact that tick-free cycles do not advance the timers.

// File: rtl/lbq_pkg.sv
package lbq_pkg;

   typedef enum logic {
      LBQ_LINE_OK  = 1'b0,
      LBQ_BROWNOUT = 1'b1
   } lbq_state_e;

   typedef struct packed {
      logic low_hit;
      logic good_hit;
   } lbq_class_t;

endpackage

// File: rtl/lbq_classify.sv
module lbq_classify
   import lbq_pkg::*;
#(
   parameter int unsigned VAL_W           = 11,
   parameter int unsigned ENTER_LVL       = 490,
   parameter int unsigned EXIT_LVL        = 564,
   parameter bit          FULLSCALE_FAULT = 1'b1
) (
   input  logic [VAL_W-1:0] val,
   output lbq_class_t       cls,
   output logic [VAL_W-1:0] depth
);
   localparam logic [VAL_W-1:0] ENTER_V = VAL_W'(ENTER_LVL);
   localparam logic [VAL_W-1:0] EXIT_V  = VAL_W'(EXIT_LVL);

   logic fault;

   generate
      if (FULLSCALE_FAULT) begin : g_fs_fault
         assign fault = &val;
      end else begin : g_fs_plain
         assign fault = 1'b0;
      end
   endgenerate

   always_comb begin
      cls.low_hit  = fault | (val <= ENTER_V);
      cls.good_hit = ~fault & (val > EXIT_V);
      if (fault)
         depth = ENTER_V;
      else if (val <= ENTER_V)
         depth = ENTER_V - val;
      else
         depth = '0;
   end
endmodule

// File: rtl/lbq_span_calc.sv
module lbq_span_calc #(
   parameter int unsigned VAL_W      = 11,
   parameter int unsigned BASE_MS    = 56,
   parameter int unsigned EXT_SHIFT  = 1,
   parameter int unsigned EXT_MAX_MS = 200,
   parameter int unsigned CNT_W      = 9
) (
   input  logic [VAL_W-1:0] depth,
   output logic [CNT_W-1:0] span
);
   localparam int unsigned RAW_TOP = ((2 ** VAL_W) - 1) >> EXT_SHIFT;

   logic [31:0] ext_raw;
   logic [31:0] ext_cap;

   assign ext_raw = 32'(depth) >> EXT_SHIFT;

   generate
      if (RAW_TOP <= EXT_MAX_MS) begin : g_no_clamp
         assign ext_cap = ext_raw;
      end else begin : g_clamp
         assign ext_cap = (ext_raw > 32'(EXT_MAX_MS)) ? 32'(EXT_MAX_MS) : ext_raw;
      end
   endgenerate

   assign span = CNT_W'(32'(BASE_MS) + ext_cap);
endmodule

// File: rtl/lbq_qual_timer.sv
module lbq_qual_timer #(
   parameter int unsigned CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             hit,
   input  logic             miss,
   input  logic             tick,
   input  logic [CNT_W-1:0] span,
   output logic             expire
);
   logic             armed_q, armed_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;

   always_comb begin
      armed_n = armed_q;
      if (hit)
         armed_n = 1'b1;
      else if (miss)
         armed_n = 1'b0;

      cnt_n = cnt_q;
      if (miss)
         cnt_n = '0;
      else if (tick && armed_n)
         cnt_n = cnt_q + CNT_W'(1);

      expire = en && armed_n && (cnt_n >= span);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en || expire) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         armed_q <= armed_n;
         cnt_q   <= cnt_n;
      end
   end
endmodule

// File: rtl/line_brownout_qual.sv
module line_brownout_qual
   import lbq_pkg::*;
#(
   parameter int unsigned VAL_W           = 11,
   parameter int unsigned ENTER_LVL       = 490,
   parameter int unsigned EXIT_LVL        = 564,
   parameter int unsigned ENTER_MS        = 56,
   parameter int unsigned EXIT_MS         = 56,
   parameter int unsigned EXT_SHIFT       = 1,
   parameter int unsigned EXT_MAX_MS      = 200,
   parameter bit          FULLSCALE_FAULT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_valid,
   input  logic [VAL_W-1:0] line_pct,
   input  logic             ms_tick,
   output logic             brownout,
   output logic             gate_off
);
   localparam int unsigned MAX_ENTER = ENTER_MS + EXT_MAX_MS;
   localparam int unsigned SPAN_TOP  = (MAX_ENTER > EXIT_MS) ? MAX_ENTER : EXIT_MS;
   localparam int unsigned CNT_W     = $clog2(SPAN_TOP + 1);

   initial begin
      assert (ENTER_LVL < EXIT_LVL)
         else $error("entry level must lie below exit level");
      assert (EXIT_LVL < (2 ** VAL_W) - 1)
         else $error("exit level must fit below the full-scale code");
      assert (ENTER_MS >= 1 && EXIT_MS >= 1)
         else $error("qualification times must be at least one tick");
   end

   lbq_state_e       state_q;
   lbq_class_t       cls;
   logic [VAL_W-1:0] cur_depth;
   logic [VAL_W-1:0] deep_q, deep_n;
   logic [CNT_W-1:0] enter_span;
   logic             low_s, low_miss, good_s, good_miss;
   logic             enter_expire, exit_expire;
   logic             in_ok;

   lbq_classify #(
      .VAL_W(VAL_W), .ENTER_LVL(ENTER_LVL), .EXIT_LVL(EXIT_LVL),
      .FULLSCALE_FAULT(FULLSCALE_FAULT)
   ) u_cls (
      .val(line_pct), .cls(cls), .depth(cur_depth)
   );

   assign in_ok     = (state_q == LBQ_LINE_OK);
   assign low_s     = sample_valid &  cls.low_hit;
   assign low_miss  = sample_valid & ~cls.low_hit;
   assign good_s    = sample_valid &  cls.good_hit;
   assign good_miss = sample_valid & ~cls.good_hit;

   always_comb begin
      deep_n = deep_q;
      if (low_miss)
         deep_n = '0;
      else if (low_s && (cur_depth > deep_q))
         deep_n = cur_depth;
   end

   lbq_span_calc #(
      .VAL_W(VAL_W), .BASE_MS(ENTER_MS), .EXT_SHIFT(EXT_SHIFT),
      .EXT_MAX_MS(EXT_MAX_MS), .CNT_W(CNT_W)
   ) u_span (
      .depth(deep_n), .span(enter_span)
   );

   lbq_qual_timer #(.CNT_W(CNT_W)) u_enter_tmr (
      .clk(clk), .rst_n(rst_n), .en(in_ok),
      .hit(low_s), .miss(low_miss), .tick(ms_tick),
      .span(enter_span), .expire(enter_expire)
   );

   lbq_qual_timer #(.CNT_W(CNT_W)) u_exit_tmr (
      .clk(clk), .rst_n(rst_n), .en(~in_ok),
      .hit(good_s), .miss(good_miss), .tick(ms_tick),
      .span(CNT_W'(EXIT_MS)), .expire(exit_expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !in_ok || enter_expire)
         deep_q <= '0;
      else
         deep_q <= deep_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LBQ_BROWNOUT;
      end else begin
         case (state_q)
            LBQ_LINE_OK:  if (enter_expire) state_q <= LBQ_BROWNOUT;
            LBQ_BROWNOUT: if (exit_expire)  state_q <= LBQ_LINE_OK;
            default:      state_q <= LBQ_BROWNOUT;
         endcase
      end
   end

   assign brownout = (state_q == LBQ_BROWNOUT);
   assign gate_off = (state_q == LBQ_BROWNOUT);
endmodule

// File: rtl/lbq_checker.sv
module lbq_checker #(
   parameter int unsigned VAL_W           = 11,
   parameter int unsigned ENTER_LVL       = 490,
   parameter int unsigned EXIT_LVL        = 564,
   parameter int unsigned ENTER_MS        = 56,
   parameter int unsigned EXIT_MS         = 56,
   parameter bit          FULLSCALE_FAULT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sample_valid,
   input logic [VAL_W-1:0] line_pct,
   input logic             ms_tick,
   input logic             brownout,
   input logic             gate_off
);
   logic        is_fault, is_low, is_good;
   logic        last_low_q, last_good_q, bo_q;
   logic [15:0] tcnt_q;

   assign is_fault = FULLSCALE_FAULT && (&line_pct);
   assign is_low   = is_fault || (line_pct <= VAL_W'(ENTER_LVL));
   assign is_good  = !is_fault && (line_pct > VAL_W'(EXIT_LVL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_low_q  <= 1'b0;
         last_good_q <= 1'b0;
         bo_q        <= 1'b1;
         tcnt_q      <= '0;
      end else begin
         if (sample_valid) begin
            last_low_q  <= is_low;
            last_good_q <= is_good;
         end
         bo_q <= brownout;
         if (brownout != bo_q)
            tcnt_q <= ms_tick ? 16'd1 : 16'd0;
         else if (ms_tick && (tcnt_q != 16'hFFFF))
            tcnt_q <= tcnt_q + 16'd1;
      end
   end

   assert_enter_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brownout) |-> $past(ms_tick));

   assert_exit_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_off) |-> $past(ms_tick));

   assert_enter_min_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brownout) |-> (tcnt_q >= 16'(ENTER_MS)));

   assert_exit_min_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(brownout) |-> (tcnt_q >= 16'(EXIT_MS)));

   assert_enter_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brownout) |-> last_low_q);

   assert_exit_after_good_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(brownout) |-> last_good_q);
endmodule

bind line_brownout_qual lbq_checker #(
   .VAL_W(VAL_W), .ENTER_LVL(ENTER_LVL), .EXIT_LVL(EXIT_LVL),
   .ENTER_MS(ENTER_MS), .EXIT_MS(EXIT_MS), .FULLSCALE_FAULT(FULLSCALE_FAULT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .line_pct(line_pct),
   .ms_tick(ms_tick), .brownout(brownout), .gate_off(gate_off)
);

// File: tb/sim_line_brownout_qual.sv
`timescale 1ns/1ps
module sim_line_brownout_qual;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_valid = 1'b0;
   logic [10:0] line_pct = '0;
   logic        ms_tick = 1'b0;
   logic        brownout, gate_off;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   line_brownout_qual u0 (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .line_pct(line_pct),
      .ms_tick(ms_tick), .brownout(brownout), .gate_off(gate_off)
   );

   function automatic int exp_span(input int v);
      int d;
      if (v == 2047)     d = 490;
      else if (v <= 490) d = 490 - v;
      else               d = 0;
      d = d >> 1;
      if (d > 200) d = 200;
      return 56 + d;
   endfunction

   task automatic step(input bit sv, input int v, input bit tk);
      sample_valid = sv;
      line_pct     = 11'(v);
      ms_tick      = tk;
      @(negedge clk);
      sample_valid = 1'b0;
      ms_tick      = 1'b0;
   endtask

   task automatic chk(input string req, input bit exp_bo);
      n_run++;
      if (brownout !== exp_bo || gate_off !== exp_bo) begin
         n_fail++;
         $display("FAIL %s: brownout=%0b gate_off=%0b expected %0b",
                  req, brownout, gate_off, exp_bo);
      end
   endtask

   task automatic enter_run(input string req, input int v);
      int t;
      t = exp_span(v);
      step(1'b1, v, 1'b1);
      repeat (t - 2) step(1'b0, 0, 1'b1);
      chk(req, 1'b0);
      step(1'b0, 0, 1'b1);
      chk(req, 1'b1);
   endtask

   task automatic recover(input string req, input int v);
      step(1'b1, v, 1'b1);
      repeat (54) step(1'b0, 0, 1'b1);
      chk(req, 1'b1);
      step(1'b0, 0, 1'b1);
      chk(req, 1'b0);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 1'b1);

      recover("R7", 600);

      // R3: zero-depth entry takes the base time
      enter_run("R3", 490);
      recover("R7", 600);
      enter_run("R3", 489);
      recover("R7", 600);

      // R4: sweep of line levels, delay grows with depth
      for (int v = 0; v <= 490; v += 7) begin
         enter_run("R4", v);
         recover("R7", 600);
      end

      // R2: just above the entry level never trips
      step(1'b1, 491, 1'b1);
      repeat (300) step(1'b0, 0, 1'b1);
      chk("R2", 1'b0);

      // R5: deeper sample extends, later shallow sample does not shorten
      step(1'b1, 480, 1'b1);
      repeat (29) step(1'b0, 0, 1'b1);
      step(1'b1, 300, 1'b1);
      repeat (9) step(1'b0, 0, 1'b1);
      step(1'b1, 480, 1'b1);
      repeat (109) step(1'b0, 0, 1'b1);
      chk("R5", 1'b0);
      step(1'b0, 0, 1'b1);
      chk("R4", 1'b1);
      recover("R7", 600);

      // R6: interrupting sample restarts entry timing
      step(1'b1, 490, 1'b1);
      repeat (39) step(1'b0, 0, 1'b1);
      chk("R6", 1'b0);
      step(1'b1, 500, 1'b1);
      chk("R6", 1'b0);
      enter_run("R6", 490);
      recover("R7", 600);

      // R10: cycles without a tick do not advance
      step(1'b1, 490, 1'b0);
      for (int i = 0; i < 20; i++) begin
         step(1'b0, 0, 1'b0);
         step(1'b1, 490, 1'b0);
      end
      chk("R10", 1'b0);
      repeat (55) step(1'b0, 0, 1'b1);
      chk("R10", 1'b0);
      step(1'b0, 0, 1'b1);
      chk("R10", 1'b1);

      // R7: exit level itself does not recover, one above does
      step(1'b1, 564, 1'b1);
      repeat (100) step(1'b0, 0, 1'b1);
      chk("R7", 1'b1);
      recover("R7", 565);

      // R8: bad sample during recovery restarts exit timing
      enter_run("R3", 490);
      step(1'b1, 600, 1'b1);
      repeat (39) step(1'b0, 0, 1'b1);
      chk("R8", 1'b1);
      step(1'b1, 520, 1'b1);
      chk("R8", 1'b1);
      recover("R8", 600);

      // R9: full-scale fault code
      enter_run("R9", 2047);
      step(1'b1, 2047, 1'b1);
      repeat (100) step(1'b0, 0, 1'b1);
      chk("R9", 1'b1);
      recover("R9", 600);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run still active, expected completion");
         summary();
         $finish;
      end
   end
endmodule